// File: doc/BRIEF.md
# Bus-Slotted Accumulating Neuron

This block is one processing element of a neural array whose members share a single time-multiplexed data bus. Each bus cycle carries one source's 9-bit output and a 6-bit slot number that names the source. The element fetches the 8-bit synaptic weight stored for that slot in its own weight memory. It multiplies the bus word by that weight in its one multiplier and adds the product to a running sum. When the controller signals the end of the sweep, the element compares the sum against a programmable threshold. It then holds a saturated 9-bit result until the next sweep ends.

Because every element on the bus samples the same word, one source reaches all elements in the same cycle. A zero weight cuts a connection. An element whose weights are all zero contributes nothing to the network. A host loads weights and the threshold through a simple write port while the element is idle.

Top module: `tmx_neuron`

## Requirements
- R1: After a sweep the output is 9'h0FF (+255) when the signed weighted sum is greater than or equal to the signed threshold, and 9'h100 (-256) otherwise. The sum is the total of weight[slot] × bus word over all accepted words.
- R2: Bus words (9 bits) and weights (8 bits) are signed two's complement. The 23-bit accumulator holds 64 extreme products without wrapping.
- R3: A zero weight makes its slot contribute nothing, whatever the bus word.
- R4: With every weight zero the sum is 0, so the output depends only on whether the threshold is at or below zero.
- R5: A cycle with `bus_vld_i` low, or any bus word while the element is idle, leaves the sum unchanged.
- R6: `start_i` clears the sum, including in the middle of a sweep. Words accepted before it are discarded.
- R7: The output updates on the second rising edge after `done_i` is sampled, and holds its value at all other times. `busy_o` goes high the edge after `start_i` and drops on the edge that updates the output. A `done_i` while idle does nothing.
- R8: Weight writes (`wr_en_i`) and threshold writes (`thr_en_i`) are ignored while `busy_o` is high.
- R9: After reset, `y_o` is 0 and `busy_o` is 0.
- R10: The bus slot number, not the arrival order, selects the weight. Slots may come in any order and may repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep and clear the sum |
| bus_vld_i | input | 1 | Bus word qualifier |
| bus_data_i | input | 9 | Signed source output on the bus |
| bus_slot_i | input | 6 | Source number and weight address |
| done_i | input | 1 | End of sweep |
| wr_en_i | input | 1 | Host weight write enable |
| wr_addr_i | input | 6 | Host weight address |
| wr_data_i | input | 8 | Host weight value (signed) |
| thr_en_i | input | 1 | Host threshold write enable |
| thr_data_i | input | 23 | Signed threshold value |
| y_o | output | 9 | Thresholded result |
| busy_o | output | 1 | Sweep in progress |

## Verification
The bench sets the threshold exactly equal to each computed sum, and then one above it. A comparator using `>` instead of `>=` would then give the wrong sign. Sweeps at the extremes, with all weights -128 or 127 on bus words of -256, would expose an accumulator that is too narrow or a product that is not sign-extended, because the sum would wrap. Permuted and repeated slot orders catch a weight fetched by word count rather than by slot. Restarts in mid-sweep, gaps with junk data, idle `done_i` and host writes during a sweep catch three faults: stale products left in the pipeline, unqualified accumulation, and writes that are not gated.

// File: rtl/nrn_pkg.sv
package nrn_pkg;
  localparam int BUS_W_DEF  = 9;
  localparam int WGT_W_DEF  = 8;
  localparam int SLOTS_DEF  = 64;
endpackage

// File: rtl/nrn_wram.sv
module nrn_wram #(
  parameter int SLOTS = nrn_pkg::SLOTS_DEF,
  parameter int WGT_W = nrn_pkg::WGT_W_DEF,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WGT_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WGT_W-1:0] rdata
);
  logic [WGT_W-1:0] mem [SLOTS];
  logic [WGT_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/nrn_ctrl.sv
module nrn_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic accept,
  output logic busy,
  output logic lat
);
  logic busy_q, busy_d;
  logic d1_q, d1_d;
  logic d2_q, d2_d;

  always_comb begin
    accept = start_i | busy_q;
    d1_d   = done_i & accept;
    d2_d   = d1_q & ~start_i;
    busy_d = busy_q;
    if (start_i) begin
      busy_d = 1'b1;
    end else if (d2_q) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      d1_q   <= 1'b0;
      d2_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      d1_q   <= d1_d;
      d2_q   <= d2_d;
    end
  end

  assign busy = busy_q;
  assign lat  = d2_q;
endmodule

// File: rtl/nrn_mac.sv
module nrn_mac #(
  parameter int BUS_W = nrn_pkg::BUS_W_DEF,
  parameter int WGT_W = nrn_pkg::WGT_W_DEF,
  parameter int ACC_W = 23,
  localparam int PROD_W = BUS_W + WGT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_vld,
  input  logic [BUS_W-1:0] in_data,
  input  logic [WGT_W-1:0] wgt,
  output logic             s1_vld,
  output logic [ACC_W-1:0] acc
);
  logic              vld_q;
  logic [BUS_W-1:0]  data_q;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_q, acc_d;

  always_comb begin
    prod  = $signed(data_q) * $signed(wgt);
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (vld_q) begin
      acc_d = acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      acc_q  <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        data_q <= in_data;
      end
      acc_q <= acc_d;
    end
  end

  assign s1_vld = vld_q;
  assign acc    = acc_q;
endmodule

// File: rtl/nrn_act.sv
module nrn_act #(
  parameter int BUS_W = nrn_pkg::BUS_W_DEF,
  parameter int ACC_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat,
  input  logic [ACC_W-1:0] acc,
  input  logic             thr_we,
  input  logic [ACC_W-1:0] thr_data,
  output logic [BUS_W-1:0] y
);
  localparam logic [BUS_W-1:0] POS = {1'b0, {(BUS_W-1){1'b1}}};
  localparam logic [BUS_W-1:0] NEG = {1'b1, {(BUS_W-1){1'b0}}};

  logic [ACC_W-1:0] thr_q, thr_d;
  logic [BUS_W-1:0] y_q, y_d;

  always_comb begin
    thr_d = thr_we ? thr_data : thr_q;
    y_d   = y_q;
    if (lat) begin
      y_d = ($signed(acc) >= $signed(thr_q)) ? POS : NEG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      y_q   <= '0;
    end else begin
      thr_q <= thr_d;
      y_q   <= y_d;
    end
  end

  assign y = y_q;
endmodule

// File: rtl/tmx_neuron.sv
module tmx_neuron #(
  parameter int BUS_W = nrn_pkg::BUS_W_DEF,
  parameter int WGT_W = nrn_pkg::WGT_W_DEF,
  parameter int SLOTS = nrn_pkg::SLOTS_DEF,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ACC_W  = BUS_W + WGT_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bus_vld_i,
  input  logic [BUS_W-1:0]  bus_data_i,
  input  logic [SLOT_W-1:0] bus_slot_i,
  input  logic              done_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_addr_i,
  input  logic [WGT_W-1:0]  wr_data_i,
  input  logic              thr_en_i,
  input  logic [ACC_W-1:0]  thr_data_i,
  output logic [BUS_W-1:0]  y_o,
  output logic              busy_o
);
  logic             accept_w, busy_w, lat_w, s1_vld_w, word_w;
  logic [WGT_W-1:0] wgt_w;
  logic [ACC_W-1:0] acc_w;

  assign word_w = bus_vld_i & accept_w;

  nrn_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_i(done_i),
    .accept(accept_w), .busy(busy_w), .lat(lat_w)
  );

  nrn_wram #(.SLOTS(SLOTS), .WGT_W(WGT_W)) u_wram (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en_i & ~busy_w), .waddr(wr_addr_i), .wdata(wr_data_i),
    .re(word_w), .raddr(bus_slot_i), .rdata(wgt_w)
  );

  nrn_mac #(.BUS_W(BUS_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .in_vld(word_w),
    .in_data(bus_data_i), .wgt(wgt_w), .s1_vld(s1_vld_w), .acc(acc_w)
  );

  nrn_act #(.BUS_W(BUS_W), .ACC_W(ACC_W)) u_act (
    .clk(clk), .rst_n(rst_n), .lat(lat_w), .acc(acc_w),
    .thr_we(thr_en_i & ~busy_w), .thr_data(thr_data_i), .y(y_o)
  );

  assign busy_o = busy_w;
endmodule

// File: rtl/nrn_chk.sv
module nrn_chk #(
  parameter int BUS_W = 9,
  parameter int ACC_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic [BUS_W-1:0] y_o,
  input logic             lat,
  input logic             s1v,
  input logic [ACC_W-1:0] acc
);
  // R7
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat |=> $stable(y_o));

  // R1
  y_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_o == {1'b0, {(BUS_W-1){1'b1}}}) || (y_o == {1'b1, {(BUS_W-1){1'b0}}}) || (y_o == '0));

  // R6
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (acc == '0));

  // R5
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1v && !start_i) |=> $stable(acc));

  // R7
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && !start_i) |=> !busy_o);
endmodule

bind tmx_neuron nrn_chk #(.BUS_W(BUS_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .y_o(y_o), .lat(lat_w), .s1v(s1_vld_w), .acc(acc_w)
);

// File: tb/sim_tmx_neuron.sv
`timescale 1ns/1ps
module sim_tmx_neuron;
  localparam int ACC_W = 23;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start_i, bus_vld_i, done_i, wr_en_i, thr_en_i, busy_o;
  logic [8:0] bus_data_i, y_o;
  logic [5:0] bus_slot_i, wr_addr_i;
  logic [7:0] wr_data_i;
  logic [ACC_W-1:0] thr_data_i;

  tmx_neuron u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_vld_i(bus_vld_i),
    .bus_data_i(bus_data_i), .bus_slot_i(bus_slot_i), .done_i(done_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .thr_en_i(thr_en_i), .thr_data_i(thr_data_i), .y_o(y_o), .busy_o(busy_o)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int wm [64];
  int xs [64];
  int ss [64];
  longint thr_m = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  function automatic longint ysig();
    return longint'($signed(y_o));
  endfunction

  function automatic longint expsum(input int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += longint'(xs[i]) * longint'(wm[ss[i]]);
    return s;
  endfunction

  function automatic longint ycode(input longint s);
    return (s >= thr_m) ? 255 : -256;
  endfunction

  task automatic wr_w(input int a, input int v);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 6'(a); wr_data_i = 8'(v);
    @(negedge clk);
    wr_en_i = 1'b0;
    wm[a] = v;
  endtask

  task automatic wr_t(input longint t);
    @(negedge clk);
    thr_en_i = 1'b1; thr_data_i = ACC_W'(t);
    @(negedge clk);
    thr_en_i = 1'b0;
    thr_m = t;
  endtask

  task automatic feed(input int i);
    bus_vld_i = 1'b1; bus_data_i = 9'(xs[i]); bus_slot_i = 6'(ss[i]);
    @(negedge clk);
  endtask

  // Full sweep: start, n words (optional junk gap after each), done, then check timing and value
  task automatic run(input int n, input bit gap, input string req);
    longint old, exp;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      feed(i);
      if (gap) begin
        bus_vld_i = 1'b0; bus_data_i = 9'h0AB; bus_slot_i = 6'(i + 1);
        @(negedge clk);
      end
    end
    bus_vld_i = 1'b0;
    chk(busy_o == 1'b1, {req, " busy during sweep (R7)"}, longint'(busy_o), 1);
    old = ysig();
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    @(negedge clk);
    chk(ysig() == old, {req, " hold before update (R7)"}, ysig(), old);
    @(negedge clk);
    exp = ycode(expsum(n));
    chk(ysig() == exp, req, ysig(), exp);
    chk(busy_o == 1'b0, {req, " busy released (R7)"}, longint'(busy_o), 0);
  endtask

  initial begin
    longint s;
    rst_n = 1'b0; start_i = 0; bus_vld_i = 0; done_i = 0; wr_en_i = 0; thr_en_i = 0;
    bus_data_i = '0; bus_slot_i = '0; wr_addr_i = '0; wr_data_i = '0; thr_data_i = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(y_o == 9'h000, "R9 y after reset", longint'(y_o), 0);
    chk(busy_o == 1'b0, "R9 busy after reset", longint'(busy_o), 0);
    rst_n = 1'b1;

    // R1 R10 sweep: permuted slots, threshold at and just above the sum
    for (int seed = 0; seed < 6; seed++) begin
      for (int k = 0; k < 64; k++) wr_w(k, ((k * 37 + seed * 11) % 256) - 128);
      for (int i = 0; i < 64; i++) begin
        xs[i] = ((i * 53 + seed * 7) % 512) - 256;
        ss[i] = (i * 5 + seed) % 64;
      end
      s = expsum(64);
      wr_t(s);
      run(64, 1'b0, "R1 R10 sum at threshold");
      wr_t(s + 1);
      run(64, 1'b0, "R1 sum below threshold");
      wr_t(s - 1);
      run(64, seed[0], "R5 R1 gaps, sum above threshold");
    end

    // R10 repeated slot
    for (int i = 0; i < 20; i++) begin xs[i] = i * 13 - 130; ss[i] = 3; end
    s = expsum(20);
    wr_t(s);
    run(20, 1'b0, "R10 repeated slot at threshold");
    wr_t(s + 1);
    run(20, 1'b0, "R10 repeated slot below threshold");

    // R2 extremes
    for (int k = 0; k < 64; k++) wr_w(k, -128);
    for (int i = 0; i < 64; i++) begin xs[i] = -256; ss[i] = i; end
    wr_t(2097152);
    run(64, 1'b0, "R2 max positive sum at threshold");
    wr_t(2097153);
    run(64, 1'b0, "R2 max positive sum below threshold");
    for (int k = 0; k < 64; k++) wr_w(k, 127);
    wr_t(-2080768);
    run(64, 1'b0, "R2 max negative sum at threshold");
    wr_t(-2080767);
    run(64, 1'b0, "R2 max negative sum below threshold");

    // R3 zero weight disconnects: slot 9 zero, others -1
    for (int k = 0; k < 64; k++) wr_w(k, (k == 9) ? 0 : -1);
    xs[0] = -256; ss[0] = 9;
    xs[1] = 1;    ss[1] = 2;
    wr_t(-1);
    run(2, 1'b0, "R3 zero weight at threshold");
    wr_t(0);
    run(2, 1'b0, "R3 zero weight below threshold");

    // R4 all weights zero
    for (int k = 0; k < 64; k++) wr_w(k, 0);
    for (int i = 0; i < 64; i++) begin xs[i] = 255 - i * 7; ss[i] = 63 - i; end
    wr_t(0);
    run(64, 1'b0, "R4 all zero, threshold 0");
    wr_t(1);
    run(64, 1'b0, "R4 all zero, threshold 1");

    // R6 restart mid-sweep discards earlier words
    for (int k = 0; k < 64; k++) wr_w(k, (k % 7) - 3);
    for (int i = 0; i < 10; i++) begin xs[i] = i * 20 - 90; ss[i] = i * 3; end
    s = expsum(10);
    wr_t(s);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    bus_vld_i = 1'b1; bus_data_i = 9'h100; bus_slot_i = 6'd0;   // weight -3 times -256
    @(negedge clk);
    bus_vld_i = 1'b1; bus_data_i = 9'h100; bus_slot_i = 6'd7;
    @(negedge clk);
    bus_vld_i = 1'b0;
    run(10, 1'b0, "R6 restart at threshold");
    wr_t(s + 1);
    run(10, 1'b0, "R6 restart below threshold");

    // R5 bus words and done while idle change nothing
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bus_vld_i = 1'b1; bus_data_i = 9'h0FF; bus_slot_i = 6'(i);
    end
    @(negedge clk);
    bus_vld_i = 1'b0; done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(ysig() == -256, "R7 done while idle", ysig(), -256);
    chk(busy_o == 1'b0, "R7 idle stays idle", longint'(busy_o), 0);
    run(10, 1'b0, "R5 idle words not counted");

    // R8 host writes during a sweep are ignored
    wr_t(s);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wr_en_i = 1'b1; wr_addr_i = 6'd3; wr_data_i = 8'd100;
    thr_en_i = 1'b1; thr_data_i = ACC_W'(4000000);
    @(negedge clk);
    wr_en_i = 1'b0; thr_en_i = 1'b0;
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    repeat (2) @(negedge clk);
    run(10, 1'b0, "R8 weight and threshold kept");

    finish_up();
  end
endmodule